// File: doc/BRIEF.md
# Real-Time Clock Sub-Second Carry and Read-Collision Flag Unit

This block is a slice of a real-time clock. It holds a 64-step sub-second counter advanced by an external 64 Hz tick and a seconds counter (0 to 59) that advances each time the sub-second counter wraps. It also holds one control/status byte. That byte carries a carry flag, an alarm flag and an interrupt enable for each flag.

The carry flag warns software that a counter value it just read may be torn. The flag is set when software reads either counter in the same clock cycle as the tick that wraps the sub-second counter. Software then reads the counters again. Software can also set or clear the carry flag directly through the control byte.

The alarm flag is raised by a one-cycle match pulse from an external comparator. Each flag drives a level interrupt through its own enable. Neither flag has a meaningful value at power-up, so the block reports a validity bit for each one. The carry flag becomes valid when a divider-reset request arrives. The alarm flag becomes valid once both an alarm value and a counter value have been loaded.

Top module: `rtc_carry_guard`

## Requirements
- R1: After reset, both counters read 0, the control byte reads 0x00, both validity outputs are 0 and both interrupt outputs are 0.
- R2: Each cycle with `tick_64` high (and no divider reset and no write to the sub-second counter) advances the sub-second counter by one. Going from 63 to 0 advances the seconds counter, and the seconds counter wraps from 59 to 0.
- R3: A read of address 0 (sub-second) or address 1 (seconds) in a cycle where `tick_64` wraps the sub-second counter sets the carry flag (control bit 7) at the next clock edge. The read itself returns the pre-tick value.
- R4: The carry flag is left unchanged by a counter read with a non-wrapping tick, by a counter read at count 63 without a tick, and by a control-byte read during a wrapping tick.
- R5: Writing the control byte (address 2) loads bit 7 into the carry flag, so 1 sets the flag and 0 clears it. Bit 4 is the alarm interrupt enable and bit 3 is the carry interrupt enable; both are loaded on every control write.
- R6: `div_reset` zeroes the sub-second counter and clears the carry flag at the next edge, overriding a tick or a carry-flag write in the same cycle, and it sets `carry_valid` permanently.
- R7: `alarm_valid` goes high only after at least one `alarm_load` pulse and at least one write to a counter (address 0 or 1) have both occurred, and then stays high.
- R8: An `alarm_match` pulse sets the alarm flag (control bit 0). A control write with bit 0 clear clears it, unless `alarm_match` is high in that same cycle. Writing 1 to bit 0 never sets it.
- R9: `irq_carry` is high exactly when the carry flag, the carry enable and `carry_valid` are all high. `irq_alarm` is high exactly when the alarm flag, the alarm enable and `alarm_valid` are all high.
- R10: Control bits 6, 5, 2 and 1 always read 0 whatever is written, and address 3 always reads 0x00.
- R11: A write to address 0 or 1 loads the low six data bits into that counter. A sub-second write wins over a tick in the same cycle and suppresses that cycle's carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_64 | input | 1 | One-cycle 64 Hz advance pulse |
| div_reset | input | 1 | Divider-reset request |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 sub-second, 1 seconds, 2 control, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| alarm_load | input | 1 | Pulse marking that an alarm value has been loaded |
| alarm_match | input | 1 | One-cycle alarm comparator hit |
| carry_valid | output | 1 | Carry flag holds a defined value |
| alarm_valid | output | 1 | Alarm flag holds a defined value |
| irq_carry | output | 1 | Carry interrupt request (level) |
| irq_alarm | output | 1 | Alarm interrupt request (level) |

## Verification
The bench sweeps more than a full minute of ticks and reads a counter on every tick, so every wrap is a colliding read. A design that tests the wrong count or the wrong edge would set the flag on ordinary ticks or miss the wrap. The near misses are a tick at 62, count 63 with no tick, and a control read at the wrap; a detector keyed on the tick alone, or on any read, sets the flag on these. The priority cases are a divider reset with a tick, an alarm match with a clearing write, and a write of 1 to the alarm bit. An inverted priority shows up as a count of 1, a lost alarm, or a flag set by software. Interrupts are checked before each validity condition is met, so an ungated request fires early.

// File: rtl/rtc_cg_pkg.sv
package rtc_cg_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_SUB   = 2'd0,
        ADDR_SEC   = 2'd1,
        ADDR_CTRL  = 2'd2,
        ADDR_SPARE = 2'd3
    } reg_addr_e;

    localparam int CTRL_CF_BIT  = 7;
    localparam int CTRL_AIE_BIT = 4;
    localparam int CTRL_CIE_BIT = 3;
    localparam int CTRL_AF_BIT  = 0;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [ADDR_W-1:0] addr;
    } bus_req_t;

    typedef struct packed {
        logic rd_cnt;
        logic wr_sub;
        logic wr_sec;
        logic wr_ctrl;
    } reg_strobe_t;

    typedef struct packed {
        logic cf;
        logic aie;
        logic cie;
        logic af;
    } ctrl_t;

    function automatic reg_strobe_t decode_req(bus_req_t req);
        reg_strobe_t s;
        s.rd_cnt  = req.rd && ((req.addr == ADDR_SUB) || (req.addr == ADDR_SEC));
        s.wr_sub  = req.wr && (req.addr == ADDR_SUB);
        s.wr_sec  = req.wr && (req.addr == ADDR_SEC);
        s.wr_ctrl = req.wr && (req.addr == ADDR_CTRL);
        return s;
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctrl(ctrl_t c);
        logic [BUS_W-1:0] b;
        b               = '0;
        b[CTRL_CF_BIT]  = c.cf;
        b[CTRL_AIE_BIT] = c.aie;
        b[CTRL_CIE_BIT] = c.cie;
        b[CTRL_AF_BIT]  = c.af;
        return b;
    endfunction

    function automatic ctrl_t unpack_ctrl(logic [BUS_W-1:0] b);
        ctrl_t c;
        c.cf  = b[CTRL_CF_BIT];
        c.aie = b[CTRL_AIE_BIT];
        c.cie = b[CTRL_CIE_BIT];
        c.af  = b[CTRL_AF_BIT];
        return c;
    endfunction

endpackage

// File: rtl/rtc_cg_wrapcnt.sv
module rtc_cg_wrapcnt #(
    parameter int MOD = 64,
    localparam int W  = (MOD > 1) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_max
);

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (inc) begin
            if (count_q == W'(MOD - 1)) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + W'(1);
            end
        end
    end

    assign count  = count_q;
    assign at_max = (count_q == W'(MOD - 1));

endmodule

// File: rtl/rtc_cg_counters.sv
module rtc_cg_counters #(
    parameter int SUB_MOD = 64,
    parameter int SEC_MOD = 60,
    localparam int SUB_W  = $clog2(SUB_MOD),
    localparam int SEC_W  = $clog2(SEC_MOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             div_reset,
    input  logic             wr_sub,
    input  logic             wr_sec,
    input  logic [SUB_W-1:0] sub_wval,
    input  logic [SEC_W-1:0] sec_wval,
    output logic [SUB_W-1:0] sub_cnt,
    output logic [SEC_W-1:0] sec_cnt,
    output logic             carry
);

    logic sub_max;
    logic sec_max;

    // The sub-second stage carries only when it really advances past its top.
    assign carry = tick && sub_max && !div_reset && !wr_sub;

    rtc_cg_wrapcnt #(.MOD(SUB_MOD)) sub_stage_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (div_reset),
        .load     (wr_sub),
        .load_val (sub_wval),
        .inc      (tick),
        .count    (sub_cnt),
        .at_max   (sub_max)
    );

    rtc_cg_wrapcnt #(.MOD(SEC_MOD)) sec_stage_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (1'b0),
        .load     (wr_sec),
        .load_val (sec_wval),
        .inc      (carry),
        .count    (sec_cnt),
        .at_max   (sec_max)
    );

    // The top of the seconds range is only of interest to a next stage.
    logic sec_max_unused;
    assign sec_max_unused = sec_max;

endmodule

// File: rtl/rtc_cg_flags.sv
module rtc_cg_flags
    import rtc_cg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_cnt,
    input  logic  wr_cnt,
    input  logic  wr_ctrl,
    input  ctrl_t wr_val,
    input  logic  carry,
    input  logic  div_reset,
    input  logic  alarm_match,
    input  logic  alarm_load,
    output ctrl_t ctrl,
    output logic  carry_valid,
    output logic  alarm_valid,
    output logic  irq_carry,
    output logic  irq_alarm
);

    ctrl_t ctrl_q, ctrl_d;
    logic  cvalid_q;
    logic  aload_seen_q;
    logic  cload_seen_q;
    logic  collision;

    assign collision = rd_cnt && carry;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.aie = wr_val.aie;
            ctrl_d.cie = wr_val.cie;
        end
        if (div_reset) begin
            ctrl_d.cf = 1'b0;
        end else if (collision) begin
            ctrl_d.cf = 1'b1;
        end else if (wr_ctrl) begin
            ctrl_d.cf = wr_val.cf;
        end
        if (alarm_match) begin
            ctrl_d.af = 1'b1;
        end else if (wr_ctrl && !wr_val.af) begin
            ctrl_d.af = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            cvalid_q     <= 1'b0;
            aload_seen_q <= 1'b0;
            cload_seen_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            if (div_reset)  cvalid_q     <= 1'b1;
            if (alarm_load) aload_seen_q <= 1'b1;
            if (wr_cnt)     cload_seen_q <= 1'b1;
        end
    end

    assign ctrl        = ctrl_q;
    assign carry_valid = cvalid_q;
    assign alarm_valid = aload_seen_q && cload_seen_q;
    assign irq_carry   = ctrl_q.cf && ctrl_q.cie && cvalid_q;
    assign irq_alarm   = ctrl_q.af && ctrl_q.aie && aload_seen_q && cload_seen_q;

endmodule

// File: rtl/rtc_cg_regif.sv
module rtc_cg_regif
    import rtc_cg_pkg::*;
#(
    parameter int SUB_W = 6,
    parameter int SEC_W = 6
) (
    input  bus_req_t          req,
    input  logic [SUB_W-1:0]  sub_cnt,
    input  logic [SEC_W-1:0]  sec_cnt,
    input  ctrl_t             ctrl,
    output reg_strobe_t       strobes,
    output logic [BUS_W-1:0]  rdata
);

    assign strobes = decode_req(req);

    always_comb begin
        unique case (req.addr)
            ADDR_SUB:  rdata = BUS_W'(sub_cnt);
            ADDR_SEC:  rdata = BUS_W'(sec_cnt);
            ADDR_CTRL: rdata = pack_ctrl(ctrl);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_carry_guard.sv
module rtc_carry_guard
    import rtc_cg_pkg::*;
#(
    parameter int SUB_MOD = 64,
    parameter int SEC_MOD = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_64,
    input  logic              div_reset,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              alarm_load,
    input  logic              alarm_match,
    output logic              carry_valid,
    output logic              alarm_valid,
    output logic              irq_carry,
    output logic              irq_alarm
);

    localparam int SUB_W = $clog2(SUB_MOD);
    localparam int SEC_W = $clog2(SEC_MOD);

    bus_req_t         req;
    reg_strobe_t      strobes;
    ctrl_t            ctrl;
    logic [SUB_W-1:0] sub_cnt;
    logic [SEC_W-1:0] sec_cnt;
    logic             carry;
    logic             carry_flag;
    logic             alarm_flag;

    assign req.rd   = bus_rd;
    assign req.wr   = bus_wr;
    assign req.addr = bus_addr;

    rtc_cg_regif #(.SUB_W(SUB_W), .SEC_W(SEC_W)) regif_i (
        .req     (req),
        .sub_cnt (sub_cnt),
        .sec_cnt (sec_cnt),
        .ctrl    (ctrl),
        .strobes (strobes),
        .rdata   (bus_rdata)
    );

    rtc_cg_counters #(.SUB_MOD(SUB_MOD), .SEC_MOD(SEC_MOD)) counters_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_64),
        .div_reset (div_reset),
        .wr_sub    (strobes.wr_sub),
        .wr_sec    (strobes.wr_sec),
        .sub_wval  (bus_wdata[SUB_W-1:0]),
        .sec_wval  (bus_wdata[SEC_W-1:0]),
        .sub_cnt   (sub_cnt),
        .sec_cnt   (sec_cnt),
        .carry     (carry)
    );

    rtc_cg_flags flags_i (
        .clk         (clk),
        .rst         (rst),
        .rd_cnt      (strobes.rd_cnt),
        .wr_cnt      (strobes.wr_sub || strobes.wr_sec),
        .wr_ctrl     (strobes.wr_ctrl),
        .wr_val      (unpack_ctrl(bus_wdata)),
        .carry       (carry),
        .div_reset   (div_reset),
        .alarm_match (alarm_match),
        .alarm_load  (alarm_load),
        .ctrl        (ctrl),
        .carry_valid (carry_valid),
        .alarm_valid (alarm_valid),
        .irq_carry   (irq_carry),
        .irq_alarm   (irq_alarm)
    );

    assign carry_flag = ctrl.cf;
    assign alarm_flag = ctrl.af;

endmodule

// File: rtl/rtc_carry_guard_chk.sv
module rtc_carry_guard_chk #(
    parameter int SUB_MOD = 64,
    parameter int SEC_MOD = 60,
    localparam int SW     = $clog2(SUB_MOD),
    localparam int CW     = $clog2(SEC_MOD)
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_64,
    input logic          div_reset,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [1:0]    bus_addr,
    input logic [7:0]    bus_rdata,
    input logic          alarm_load,
    input logic          alarm_match,
    input logic [SW-1:0] sub_cnt,
    input logic [CW-1:0] sec_cnt,
    input logic          carry_flag,
    input logic          alarm_flag,
    input logic          carry_valid,
    input logic          alarm_valid,
    input logic          irq_carry,
    input logic          irq_alarm
);

    logic seen_load_q;
    logic wr_sub;
    logic wr_sec;
    logic wraps;

    always_ff @(posedge clk) begin
        if (rst) seen_load_q <= 1'b0;
        else if (alarm_load) seen_load_q <= 1'b1;
    end

    assign wr_sub = bus_wr && (bus_addr == 2'd0);
    assign wr_sec = bus_wr && (bus_addr == 2'd1);
    assign wraps  = tick_64 && !div_reset && !wr_sub && (sub_cnt == SW'(SUB_MOD - 1));

    // R2
    sub_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_64 && !div_reset && !wr_sub && sub_cnt != SW'(SUB_MOD - 1))
        |=> sub_cnt == SW'($past(sub_cnt) + SW'(1)));

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wraps && !wr_sec && sec_cnt == CW'(SEC_MOD - 1)) |=> sec_cnt == '0);

    // R3
    collide_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wraps && bus_rd && !bus_wr && bus_addr <= 2'd1) |=> carry_flag);

    // R6
    div_reset_chk: assert property (@(posedge clk) disable iff (rst)
        div_reset |=> (sub_cnt == '0 && !carry_flag && carry_valid));

    // R6
    carry_valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        carry_valid |=> carry_valid);

    // R7
    alarm_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_valid |-> seen_load_q);

    // R8
    alarm_set_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_match |=> alarm_flag);

    // R9
    irq_carry_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !carry_valid |-> !irq_carry);

    // R9
    irq_alarm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !alarm_valid |-> !irq_alarm);

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd2) |-> (bus_rdata[6:5] == 2'b00 && bus_rdata[2:1] == 2'b00));

    // R10
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> bus_rdata == 8'h00);

endmodule

bind rtc_carry_guard rtc_carry_guard_chk #(.SUB_MOD(SUB_MOD), .SEC_MOD(SEC_MOD)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .tick_64     (tick_64),
    .div_reset   (div_reset),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .alarm_load  (alarm_load),
    .alarm_match (alarm_match),
    .sub_cnt     (sub_cnt),
    .sec_cnt     (sec_cnt),
    .carry_flag  (carry_flag),
    .alarm_flag  (alarm_flag),
    .carry_valid (carry_valid),
    .alarm_valid (alarm_valid),
    .irq_carry   (irq_carry),
    .irq_alarm   (irq_alarm)
);

// File: tb/rtc_carry_guard_tb_top.sv
`timescale 1ns/1ps
module rtc_carry_guard_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_64 = 1'b0;
    logic       div_reset = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       alarm_load = 1'b0;
    logic       alarm_match = 1'b0;
    logic       carry_valid, alarm_valid, irq_carry, irq_alarm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state, built from the requirements
    int m_sub = 0, m_sec = 0;
    bit m_cf = 0, m_aie = 0, m_cie = 0, m_af = 0;
    bit m_cv = 0, m_al = 0, m_cl = 0;

    always #2.5 clk = ~clk;

    rtc_carry_guard dut_i (
        .clk(clk), .rst(rst), .tick_64(tick_64), .div_reset(div_reset),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_load(alarm_load), .alarm_match(alarm_match),
        .carry_valid(carry_valid), .alarm_valid(alarm_valid),
        .irq_carry(irq_carry), .irq_alarm(irq_alarm)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_read(bit [1:0] a);
        case (a)
            2'd0: return m_sub;
            2'd1: return m_sec;
            2'd2: return (int'(m_cf) << 7) | (int'(m_aie) << 4) | (int'(m_cie) << 3) | int'(m_af);
            default: return 0;
        endcase
    endfunction

    // One bus cycle, started and ended at a falling edge.
    task automatic step(bit tk, bit rd, bit wr, bit [1:0] a, bit [7:0] wd,
                        bit dr, bit am, bit al, string tag);
        bit wrap;
        tick_64 = tk; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        div_reset = dr; alarm_match = am; alarm_load = al;
        #1;
        if (rd) chk(tag, int'(bus_rdata), exp_read(a));
        wrap = tk && !dr && !(wr && a == 2'd0) && m_sub == 63;
        // next reference state
        if (wr && a == 2'd2) begin m_aie = wd[4]; m_cie = wd[3]; end
        if (dr) m_cf = 0;
        else if (wrap && rd && a <= 2'd1) m_cf = 1;
        else if (wr && a == 2'd2) m_cf = wd[7];
        if (am) m_af = 1;
        else if (wr && a == 2'd2 && !wd[0]) m_af = 0;
        if (wr && a == 2'd1) m_sec = int'(wd[5:0]);
        else if (wrap) m_sec = (m_sec + 1) % 64;
        if (dr) m_sub = 0;
        else if (wr && a == 2'd0) m_sub = int'(wd[5:0]);
        else if (tk) m_sub = (m_sub + 1) % 64;
        if (wrap && m_sec == 60 && !(wr && a == 2'd1)) m_sec = 0;
        if (dr) m_cv = 1;
        if (al) m_al = 1;
        if (wr && a <= 2'd1) m_cl = 1;
        @(posedge clk);
        @(negedge clk);
        tick_64 = 0; bus_rd = 0; bus_wr = 0; div_reset = 0;
        alarm_match = 0; alarm_load = 0;
        chk("R9 irq_carry", int'(irq_carry), int'(m_cf && m_cie && m_cv));
        chk("R9 irq_alarm", int'(irq_alarm), int'(m_af && m_aie && m_al && m_cl));
        chk("R6 carry_valid", int'(carry_valid), int'(m_cv));
        chk("R7 alarm_valid", int'(alarm_valid), int'(m_al && m_cl));
    endtask

    task automatic rd_reg(bit [1:0] a, string tag);
        step(0, 1, 0, a, 8'h00, 0, 0, 0, tag);
    endtask

    task automatic wr_reg(bit [1:0] a, bit [7:0] d, string tag);
        step(0, 0, 1, a, d, 0, 0, 0, tag);
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 irq_carry", int'(irq_carry), 0);
        chk("R1 irq_alarm", int'(irq_alarm), 0);
        chk("R1 carry_valid", int'(carry_valid), 0);
        chk("R1 alarm_valid", int'(alarm_valid), 0);
        rd_reg(2'd0, "R1"); rd_reg(2'd1, "R1"); rd_reg(2'd2, "R1");

        // R9: flag and enable set but carry not yet valid
        wr_reg(2'd2, 8'h88, "R5");
        rd_reg(2'd2, "R5");
        chk("R9 gated before valid", int'(irq_carry), 0);
        // R6: divider reset with tick in the same cycle and a write-1 in flight
        step(1, 0, 0, 2'd0, 8'h00, 1, 0, 0, "R6");
        rd_reg(2'd0, "R6");
        rd_reg(2'd2, "R6");
        wr_reg(2'd2, 8'h88, "R5");
        chk("R9 carry irq", int'(irq_carry), 1);
        wr_reg(2'd2, 8'h08, "R5");
        chk("R5 clear", int'(irq_carry), 0);
        // R10 reserved bits and spare address
        wr_reg(2'd2, 8'hFF, "R10");
        rd_reg(2'd2, "R10");
        rd_reg(2'd3, "R10");
        wr_reg(2'd2, 8'h00, "R10");

        // R2/R3 sweep: read a counter on every tick, over a full minute
        for (int i = 0; i < 64 * 61 + 5; i++) begin
            bit coll;
            coll = (m_sub == 63);
            step(1, 1, 0, 2'(i % 2), 8'h00, 0, 0, 0, coll ? "R3" : "R2");
            if (coll) begin
                rd_reg(2'd2, "R3");
                wr_reg(2'd2, 8'h00, "R5");
                rd_reg(2'd2, "R5");
            end
        end

        // R4 near misses
        while (m_sub != 62) step(1, 0, 0, 2'd0, 8'h00, 0, 0, 0, "R2");
        step(1, 1, 0, 2'd0, 8'h00, 0, 0, 0, "R4");
        step(0, 1, 0, 2'd1, 8'h00, 0, 0, 0, "R4");
        step(1, 1, 0, 2'd2, 8'h00, 0, 0, 0, "R4");
        rd_reg(2'd2, "R4");
        rd_reg(2'd1, "R4");

        // R8 / R7: alarm before any counter load stays invalid
        step(0, 0, 0, 2'd0, 8'h00, 0, 1, 0, "R8");
        wr_reg(2'd2, 8'h10, "R8");
        step(0, 0, 0, 2'd0, 8'h00, 0, 1, 1, "R7");
        chk("R7 only alarm loaded", int'(alarm_valid), 0);

        // R11 counter writes; also completes alarm validity
        step(1, 0, 1, 2'd0, 8'd63, 0, 0, 0, "R11");
        rd_reg(2'd0, "R11");
        chk("R7 both loaded", int'(alarm_valid), 1);
        wr_reg(2'd1, 8'd59, "R11");
        step(1, 1, 0, 2'd2, 8'h00, 0, 0, 0, "R11");
        rd_reg(2'd0, "R11");
        rd_reg(2'd1, "R11");

        // R8 priorities: match beats clear, write-1 does not set
        step(0, 0, 1, 2'd2, 8'h10, 0, 1, 0, "R8");
        rd_reg(2'd2, "R8");
        wr_reg(2'd2, 8'h10, "R8");
        rd_reg(2'd2, "R8");
        wr_reg(2'd2, 8'h11, "R8");
        rd_reg(2'd2, "R8");
        step(0, 0, 0, 2'd0, 8'h00, 0, 1, 0, "R8");
        chk("R9 alarm irq", int'(irq_alarm), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule